// File: doc/BRIEF.md
# Peripheral Gating and Unlock Register

This block is an 8-bit control register on a byte-wide I/O bus. It sits between the bus and two peripheral address windows. Each window has an enable bit. While that bit is set, reads from the window pass the peripheral's data through, and writes raise the peripheral's write strobe. While the bit is clear, the block drops writes to the window. Reads from the window then return a fixed 4-byte signature, chosen by the two low address bits, so the pattern repeats every four bytes across the window. The second window's signature depends on a hardware revision input.

A third bit is an unlock flag. It qualifies access to protected ports and a flash unlock path, so it is brought out as an output. Whenever a pulse marks entry into the privileged interrupt handler, the flag is cleared. One register bit reads back an external flash-lock status input. Register reads and window substitution are combinational from the address, so data is available in the same cycle.

Top module: `periph_gate_ctrl`

## Requirements
- R1: After reset the register holds window-A enable (bit 0) = 1, window-B enable (bit 1) = 1 and unlock (bit 2) = 0.
- R2: A bus write to the register address latches wdata bits 0, 1 and 2 into the window-A enable, window-B enable and unlock bits on the next clock edge.
- R3: While bit 0 is 0, a write inside window A raises no per_wr_a strobe. A read there returns 0x20, 0x0E, 0x3E or 0x00 for address bits [1:0] = 0, 1, 2 or 3.
- R4: While a window's enable bit is 1, a read inside it returns that peripheral's read data in the same cycle, and a write there raises that window's write strobe in the same cycle.
- R5: While bit 1 is 0, a write inside window B raises no per_wr_b strobe. A read there returns bytes indexed by address bits [1:0]: 0xB1, 0x00, 0x00, 0x00 when hw_rev = 0, and 0x2D, 0x09, 0x00, 0x00 when hw_rev = 1.
- R6: The unlock output equals register bit 2.
- R7: An irq_entry pulse clears bit 2 on the next edge. This clear wins over a register write that sets bit 2 in the same cycle.
- R8: A register read returns the flash_locked input on bit 4.
- R9: Register bits 3, 5, 6 and 7 always read 0, and writing 1 to them has no effect on any readback.
- R10: An address that is neither the register nor inside a window reads 0x00 and raises no peripheral write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Bus write enable for this cycle |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| per_rdata_a | input | 8 | Read data from peripheral A |
| per_rdata_b | input | 8 | Read data from peripheral B |
| per_wr_a | output | 1 | Write strobe to peripheral A, blocked while gated |
| per_wr_b | output | 1 | Write strobe to peripheral B, blocked while gated |
| hw_rev | input | 1 | Revision select for the window-B signature |
| irq_entry | input | 1 | One-cycle pulse on privileged handler entry |
| flash_locked | input | 1 | Flash-lock status shown on register bit 4 |
| unlock | output | 1 | Unlock flag for protected ports and the flash unlock path |

## Verification
The bench builds the block with an 8-bit address, the register at 0x06 and 16-byte windows at 0x40 and 0x80. With this setup every one of the 256 addresses can be swept for read data and write strobes. The sweep runs under all eight combinations of the two enables and the revision input, so each signature byte, each pass-through path and the unmapped space are all compared against values computed in the bench. Single-cycle sequences around irq_entry cover the clear-over-set priority.

// File: rtl/pgu_pkg.sv
package pgu_pkg;

    localparam int BIT_EN_A   = 0;
    localparam int BIT_EN_B   = 1;
    localparam int BIT_UNLOCK = 2;
    localparam int BIT_FLOCK  = 4;
    localparam int NUM_WIN    = 2;

    typedef struct packed {
        logic unlock;
        logic en_b;
        logic en_a;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{unlock: 1'b0, en_b: 1'b1, en_a: 1'b1};

    // signature words, byte 0 in the low bits
    localparam logic [31:0] SIG_A      = 32'h003E_0E20;
    localparam logic [31:0] SIG_B_REV0 = 32'h0000_00B1;
    localparam logic [31:0] SIG_B_REV1 = 32'h0000_092D;

    function automatic logic [7:0] sig_byte(input logic [31:0] word, input logic [1:0] idx);
        return word[{idx, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/pgu_decode.sv
module pgu_decode #(
    parameter int                 ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]  CTRL_ADDR = 16'h0006
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              ctrl_hit,
    output logic              ctrl_wr
);
    always_comb begin
        ctrl_hit = (addr == CTRL_ADDR);
        ctrl_wr  = ctrl_hit && wr;
    end
endmodule

// File: rtl/pgu_ctrl_reg.sv
module pgu_ctrl_reg
    import pgu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wbits,
    input  logic        irq_clr,
    output ctrl_t       ctrl_q
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.en_a   = wbits[BIT_EN_A];
            ctrl_d.en_b   = wbits[BIT_EN_B];
            ctrl_d.unlock = wbits[BIT_UNLOCK];
        end
        // handler entry overrides any simultaneous set
        if (irq_clr) begin
            ctrl_d.unlock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end
endmodule

// File: rtl/pgu_win_gate.sv
module pgu_win_gate
    import pgu_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                WIN_LOG2 = 12,
    parameter logic [ADDR_W-1:0] BASE     = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              en,
    input  logic [7:0]        per_rdata,
    input  logic [31:0]       sig_word,
    output logic              hit,
    output logic              per_wr,
    output logic [7:0]        rdata
);
    localparam int TAG_LSB = WIN_LOG2;

    logic [7:0] sig_rd;

    always_comb begin
        hit    = (addr[ADDR_W-1:TAG_LSB] == BASE[ADDR_W-1:TAG_LSB]);
        per_wr = hit && wr && en;
        sig_rd = sig_byte(sig_word, addr[1:0]);
        rdata  = en ? per_rdata : sig_rd;
    end
endmodule

// File: rtl/periph_gate_ctrl.sv
module periph_gate_ctrl
    import pgu_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 16'h0006,
    parameter logic [ADDR_W-1:0] WIN_A_BASE = 16'h3000,
    parameter logic [ADDR_W-1:0] WIN_B_BASE = 16'h4000,
    parameter int                WIN_LOG2   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        per_rdata_a,
    input  logic [7:0]        per_rdata_b,
    output logic              per_wr_a,
    output logic              per_wr_b,
    input  logic              hw_rev,
    input  logic              irq_entry,
    input  logic              flash_locked,
    output logic              unlock
);
    logic        ctrl_hit;
    logic        ctrl_wr;
    ctrl_t       ctrl_q;
    logic [7:0]  ctrl_rd;

    logic [7:0]  win_prd [NUM_WIN];
    logic [31:0] win_sig [NUM_WIN];
    logic        win_en  [NUM_WIN];
    logic        win_hit [NUM_WIN];
    logic        win_wr  [NUM_WIN];
    logic [7:0]  win_rd  [NUM_WIN];

    pgu_decode #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) i_decode (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .ctrl_hit (ctrl_hit),
        .ctrl_wr  (ctrl_wr)
    );

    pgu_ctrl_reg i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr),
        .wbits   (bus_wdata[2:0]),
        .irq_clr (irq_entry),
        .ctrl_q  (ctrl_q)
    );

    always_comb begin
        win_prd[0] = per_rdata_a;
        win_prd[1] = per_rdata_b;
        win_en[0]  = ctrl_q.en_a;
        win_en[1]  = ctrl_q.en_b;
        win_sig[0] = SIG_A;
        win_sig[1] = hw_rev ? SIG_B_REV1 : SIG_B_REV0;
    end

    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
        pgu_win_gate #(
            .ADDR_W   (ADDR_W),
            .WIN_LOG2 (WIN_LOG2),
            .BASE     ((gi == 0) ? WIN_A_BASE : WIN_B_BASE)
        ) i_gate (
            .addr      (bus_addr),
            .wr        (bus_wr),
            .en        (win_en[gi]),
            .per_rdata (win_prd[gi]),
            .sig_word  (win_sig[gi]),
            .hit       (win_hit[gi]),
            .per_wr    (win_wr[gi]),
            .rdata     (win_rd[gi])
        );
    end

    always_comb begin
        ctrl_rd             = '0;
        ctrl_rd[BIT_EN_A]   = ctrl_q.en_a;
        ctrl_rd[BIT_EN_B]   = ctrl_q.en_b;
        ctrl_rd[BIT_UNLOCK] = ctrl_q.unlock;
        ctrl_rd[BIT_FLOCK]  = flash_locked;
    end

    always_comb begin
        bus_rdata = '0;
        if (ctrl_hit) begin
            bus_rdata = ctrl_rd;
        end
        for (int i = 0; i < NUM_WIN; i++) begin
            if (win_hit[i]) begin
                bus_rdata = win_rd[i];
            end
        end
        per_wr_a = win_wr[0];
        per_wr_b = win_wr[1];
        unlock   = ctrl_q.unlock;
    end
endmodule

// File: rtl/periph_gate_ctrl_chk.sv
module periph_gate_ctrl_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0006
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              per_wr_a,
    input logic              per_wr_b,
    input logic              irq_entry,
    input logic              flash_locked,
    input logic              unlock
);
    // R7
    irq_clears_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_entry |=> !unlock);

    // R2
    unlock_rise_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock) |-> $past(bus_wr && bus_addr == CTRL_ADDR && bus_wdata[2] && !irq_entry));

    // R4
    strobe_a_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr_a |-> (bus_wr && bus_addr != CTRL_ADDR));

    // R4
    strobe_b_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr_b |-> (bus_wr && bus_addr != CTRL_ADDR));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == CTRL_ADDR) |-> (bus_rdata[7:5] == 3'b000 && bus_rdata[3] == 1'b0));

    // R8
    flash_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == CTRL_ADDR) |-> (bus_rdata[4] == flash_locked));

    // R6
    unlock_matches_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == CTRL_ADDR) |-> (bus_rdata[2] == unlock));
endmodule

bind periph_gate_ctrl periph_gate_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR)
) i_chk (.*);

// File: tb/test_periph_gate_ctrl.sv
`timescale 1ns/1ps
module test_periph_gate_ctrl;
    localparam int              AW   = 8;
    localparam logic [AW-1:0]   CADR = 8'h06;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [7:0]    per_rdata_a = 8'h5A;
    logic [7:0]    per_rdata_b = 8'hC3;
    logic          per_wr_a, per_wr_b;
    logic          hw_rev = 1'b0;
    logic          irq_entry = 1'b0;
    logic          flash_locked = 1'b0;
    logic          unlock;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    periph_gate_ctrl #(
        .ADDR_W     (AW),
        .CTRL_ADDR  (CADR),
        .WIN_A_BASE (8'h40),
        .WIN_B_BASE (8'h80),
        .WIN_LOG2   (4)
    ) i_periph_gate_ctrl (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%02h actual=%02h expected=%02h", req, bus_addr, act, exp);
        end
    endtask

    // drive at negedge, let it land on the following posedge
    task automatic reg_write(input logic [7:0] d, input logic irq);
        @(negedge clk);
        bus_addr = CADR; bus_wdata = d; bus_wr = 1'b1; irq_entry = irq;
        @(negedge clk);
        bus_wr = 1'b0; irq_entry = 1'b0; bus_wdata = '0;
        #0.5;
    endtask

    function automatic logic [7:0] sig_a(input int idx);
        case (idx)
            0: return 8'h20;
            1: return 8'h0E;
            2: return 8'h3E;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] sig_b(input logic rev, input int idx);
        if (idx == 0) return rev ? 8'h2D : 8'hB1;
        if (idx == 1) return rev ? 8'h09 : 8'h00;
        return 8'h00;
    endfunction

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #12 rst_n = 1'b1;
        @(negedge clk); #0.5;
        bus_addr = CADR; #0.5;
        check("R1 reset value", bus_rdata, 8'h03);
        check("R6 unlock after reset", {7'b0, unlock}, 8'h00);
        flash_locked = 1'b1; #0.5;
        check("R8 flash bit", bus_rdata, 8'h13);

        reg_write(8'hFF, 1'b0);
        check("R2/R9 write all ones", bus_rdata, 8'h17);
        check("R6 unlock set", {7'b0, unlock}, 8'h01);

        @(negedge clk); irq_entry = 1'b1;
        @(negedge clk); irq_entry = 1'b0; #0.5;
        check("R7 irq clears unlock", bus_rdata, 8'h13);
        check("R6 unlock cleared", {7'b0, unlock}, 8'h00);

        reg_write(8'h07, 1'b1);
        check("R7 clear beats set", bus_rdata, 8'h13);
        check("R7 unlock stays low", {7'b0, unlock}, 8'h00);

        reg_write(8'hE8, 1'b0);
        check("R9 reserved not latched", bus_rdata, 8'h10);
        flash_locked = 1'b0; #0.5;
        check("R8 flash bit clear", bus_rdata, 8'h00);

        for (int cfg = 0; cfg < 8; cfg++) begin
            logic ea, eb, rv;
            ea = cfg[0]; eb = cfg[1]; rv = cfg[2];
            hw_rev = rv;
            reg_write({6'b0, eb, ea}, 1'b0);
            for (int a = 0; a < 256; a++) begin
                logic [7:0] exp_rd;
                logic       exp_wa, exp_wb;
                exp_wa = 1'b0; exp_wb = 1'b0;
                if (a == int'(CADR)) exp_rd = {6'b0, eb, ea};
                else if (a[7:4] == 4'h4) begin
                    exp_rd = ea ? 8'h5A : sig_a(a % 4); exp_wa = ea;
                end else if (a[7:4] == 4'h8) begin
                    exp_rd = eb ? 8'hC3 : sig_b(rv, a % 4); exp_wb = eb;
                end else exp_rd = 8'h00;
                @(negedge clk);
                bus_addr = a[7:0]; #0.5;
                if (a[7:4] == 4'h4) check(ea ? "R4 window A read" : "R3 window A signature", bus_rdata, exp_rd);
                else if (a[7:4] == 4'h8) check(eb ? "R4 window B read" : "R5 window B signature", bus_rdata, exp_rd);
                else if (a != int'(CADR)) check("R10 unmapped read", bus_rdata, exp_rd);
                else check("R2 enables readback", bus_rdata, exp_rd);
                if (a != int'(CADR)) begin
                    bus_wr = 1'b1; bus_wdata = 8'hFF; #0.5;
                    check("R3/R4/R10 strobe A", {7'b0, per_wr_a}, {7'b0, exp_wa});
                    check("R5/R4/R10 strobe B", {7'b0, per_wr_b}, {7'b0, exp_wb});
                    bus_wr = 1'b0;
                end
            end
            bus_addr = CADR; #0.5;
            check("R3/R5 window writes leave register", bus_rdata, {6'b0, eb, ea});
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        done = 1'b1;
        $finish;
    end
endmodule